// File: doc/BRIEF.md
# Dual-bank USB OUT endpoint receive controller

This block handles the receive side of a single OUT endpoint on a USB device. Packets arrive from the device's protocol layer already checked and acknowledged. Each one is framed by a start strobe, followed by one byte per strobed cycle and then an end strobe. The block stores the bytes through a simple write port into one of two RAM buffers, called banks. Each bank has a descriptor holding a base address, a running byte count and a multi-packet size. The banks work in ping-pong fashion: the host fills one bank while the CPU drains the other.

The CPU sees a small register file. It holds an interrupt enable, a mode bit and the endpoint packet size. It also holds a status word with a receive flag, a busy bit for the current bank, the current-bank index and both bank-valid bits. In single-packet mode every packet completes its bank. In multi-packet mode the bytes of several packets are packed back to back. The bank completes when its count reaches the programmed size, or when a packet shorter than the endpoint size ends. While both banks are waiting for the CPU, a new packet is refused with a NAK pulse and nothing is stored.

Top module: `usb_out_pingpong`

## Requirements
- R1: After reset the status word reads 0 (current bank 0, no bank valid, receive flag 0), the configuration word reads 0, and irq and rx_nak are low.
- R2: In single-packet mode (CFG bit 1 = 0), the bank's count restarts at 0 with each accepted packet. Byte i of the packet is written to RAM address base+i. At the end strobe the count equals the packet length and the bank becomes valid.
- R3: When the current bank becomes valid, the receive flag (STAT bit 0) and busy (STAT bit 1) read 1. irq equals the receive flag ANDed with the enable (CFG bit 0), one cycle later.
- R4: Writing STAT with bit 0 = 1 clears the receive flag. Writing bit 0 = 0 leaves it unchanged.
- R5: Writing STAT with bit 1 = 1 while busy frees the current bank: its valid bit clears and the current-bank field (STAT bit 2) toggles. When the current bank is not busy, the write has no effect.
- R6: If the other bank is already valid when the current one is freed, the receive flag is set again in the next cycle, so irq rises two cycles after the freeing write.
- R7: The host side fills bank 0 and bank 1 alternately. It may fill one bank while the other is still valid and unread. The valid bits show in STAT bits 4:3 (bit 3 = bank 0).
- R8: In multi-packet mode (CFG bit 1 = 1), counts accumulate across packets. Each byte goes to base+count, so packets land back to back. The bank becomes valid once its count reaches the multi-packet size.
- R9: In multi-packet mode, a packet shorter than the endpoint size (CFG bits 16+) completes its bank, even when the bank is not full.
- R10: If a packet starts while the bank the host would fill is still valid, rx_nak pulses one cycle after the start strobe. That packet writes no RAM and changes no count.
- R11: Registers read back one cycle after the address is presented. The register map is: 0 CFG; 1 STAT; 2 and 4 the base of bank 0 and bank 1; 3 and 5 the descriptor of bank 0 and bank 1 (count in the low bits, multi-packet size from bit 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sop | input | 1 | Start of an acknowledged OUT packet |
| rx_byte_vld | input | 1 | Byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_eop | input | 1 | End of packet |
| rx_nak | output | 1 | Packet refused, both banks occupied |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Registered read data |
| irq | output | 1 | Endpoint interrupt |

## Verification
The hardest case to reach is a freeing write that lands while the opposite bank is already full. At that moment the receive flag must come back by itself, one cycle after the pointer moves. The stimulus fills both banks without servicing either and clears the flag. It then frees the current bank and samples irq on two successive cycles, so a flag that comes back late, early or never is caught. The same full state is used to fire a third packet and to confirm that the NAK leaves the counts and the RAM untouched.

// File: rtl/ob_pkg.sv
package ob_pkg;
  localparam int CPU_AW = 3;
  localparam int CPU_DW = 32;
  localparam int BYTE_W = 8;
  localparam int NBANK  = 2;
  localparam logic [CPU_AW-1:0] A_CFG   = 3'd0;
  localparam logic [CPU_AW-1:0] A_STAT  = 3'd1;
  localparam logic [CPU_AW-1:0] A_BASE0 = 3'd2;
  localparam int HI_FIELD = 16;
endpackage

// File: rtl/ob_regs.sv
module ob_regs
  import ob_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpu_we,
  input  logic [CPU_AW-1:0]           cpu_addr,
  input  logic [CPU_DW-1:0]           cpu_wdata,
  output logic [CPU_DW-1:0]           cpu_rdata,
  output logic                        cfg_ie,
  output logic                        cfg_multi,
  output logic [CNT_W-1:0]            cfg_ep_size,
  output logic [NBANK-1:0][ADDR_W-1:0] bank_base,
  output logic [NBANK-1:0][CNT_W-1:0]  bank_msize,
  output logic [NBANK-1:0]            sw_cnt_we,
  output logic [CNT_W-1:0]            sw_cnt_data,
  output logic                        clr_rx,
  output logic                        free_req,
  input  logic                        rx_flag,
  input  logic                        busy,
  input  logic                        cur_bank,
  input  logic [NBANK-1:0]            bank_valid,
  input  logic [NBANK-1:0][CNT_W-1:0]  bank_count
);
  logic stat_wr;
  logic [CPU_DW-1:0] rd_next;

  assign stat_wr     = cpu_we && (cpu_addr == A_STAT);
  assign clr_rx      = stat_wr && cpu_wdata[0];
  assign free_req    = stat_wr && cpu_wdata[1];
  assign sw_cnt_data = cpu_wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ie      <= 1'b0;
      cfg_multi   <= 1'b0;
      cfg_ep_size <= '0;
    end else if (cpu_we && cpu_addr == A_CFG) begin
      cfg_ie      <= cpu_wdata[0];
      cfg_multi   <= cpu_wdata[1];
      cfg_ep_size <= cpu_wdata[HI_FIELD +: CNT_W];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_desc
    localparam logic [CPU_AW-1:0] A_B = CPU_AW'(A_BASE0 + 2*b);
    localparam logic [CPU_AW-1:0] A_D = CPU_AW'(A_BASE0 + 2*b + 1);
    assign sw_cnt_we[b] = cpu_we && (cpu_addr == A_D);
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_base[b]  <= '0;
        bank_msize[b] <= '0;
      end else if (cpu_we) begin
        if (cpu_addr == A_B) bank_base[b]  <= cpu_wdata[ADDR_W-1:0];
        if (cpu_addr == A_D) bank_msize[b] <= cpu_wdata[HI_FIELD +: CNT_W];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (cpu_addr)
      A_CFG: begin
        rd_next[0] = cfg_ie;
        rd_next[1] = cfg_multi;
        rd_next[HI_FIELD +: CNT_W] = cfg_ep_size;
      end
      A_STAT: begin
        rd_next[0]   = rx_flag;
        rd_next[1]   = busy;
        rd_next[2]   = cur_bank;
        rd_next[4:3] = bank_valid;
      end
      3'd2: rd_next[ADDR_W-1:0] = bank_base[0];
      3'd3: begin
        rd_next[CNT_W-1:0]         = bank_count[0];
        rd_next[HI_FIELD +: CNT_W] = bank_msize[0];
      end
      3'd4: rd_next[ADDR_W-1:0] = bank_base[1];
      3'd5: begin
        rd_next[CNT_W-1:0]         = bank_count[1];
        rd_next[HI_FIELD +: CNT_W] = bank_msize[1];
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_next;
  end
endmodule

// File: rtl/ob_rx_engine.sv
module ob_rx_engine
  import ob_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rx_sop,
  input  logic                        rx_byte_vld,
  input  logic [BYTE_W-1:0]           rx_byte,
  input  logic                        rx_eop,
  input  logic                        cfg_multi,
  input  logic [CNT_W-1:0]            cfg_ep_size,
  input  logic [NBANK-1:0][ADDR_W-1:0] bank_base,
  input  logic [NBANK-1:0][CNT_W-1:0]  bank_msize,
  input  logic [NBANK-1:0]            sw_cnt_we,
  input  logic [CNT_W-1:0]            sw_cnt_data,
  input  logic                        host_bank,
  input  logic                        host_full,
  output logic [NBANK-1:0][CNT_W-1:0]  bank_count,
  output logic                        bank_done,
  output logic                        rx_nak,
  output logic                        ram_we,
  output logic [ADDR_W-1:0]           ram_addr,
  output logic [BYTE_W-1:0]           ram_wdata
);
  logic             active;
  logic [CNT_W-1:0] pkt_len;
  logic             accept;
  logic             take_byte;
  logic             cnt_clr;
  logic             short_pkt;
  logic             bank_full;

  assign accept    = rx_sop && !host_full;
  assign take_byte = active && rx_byte_vld && !rx_sop;
  assign cnt_clr   = accept && !cfg_multi;
  assign short_pkt = pkt_len < cfg_ep_size;
  assign bank_full = bank_count[host_bank] >= bank_msize[host_bank];
  assign bank_done = active && !rx_sop && !rx_byte_vld && rx_eop &&
                     (!cfg_multi || short_pkt || bank_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      pkt_len   <= '0;
      rx_nak    <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      rx_nak <= 1'b0;
      ram_we <= 1'b0;
      if (rx_sop) begin
        active  <= accept;
        rx_nak  <= host_full;
        pkt_len <= '0;
      end else if (take_byte) begin
        ram_we    <= 1'b1;
        ram_addr  <= bank_base[host_bank] + ADDR_W'(bank_count[host_bank]);
        ram_wdata <= rx_byte;
        pkt_len   <= pkt_len + 1'b1;
      end else if (rx_eop) begin
        active <= 1'b0;
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_cnt
    logic mine;
    assign mine = (host_bank == 1'(b));
    always_ff @(posedge clk) begin
      if (rst)                    bank_count[b] <= '0;
      else if (cnt_clr && mine)   bank_count[b] <= '0;
      else if (take_byte && mine) bank_count[b] <= bank_count[b] + 1'b1;
      else if (sw_cnt_we[b])      bank_count[b] <= sw_cnt_data;
    end
  end
endmodule

// File: rtl/ob_bank_ctrl.sv
module ob_bank_ctrl
  import ob_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bank_done,
  input  logic             clr_rx,
  input  logic             free_req,
  input  logic             cfg_ie,
  output logic [NBANK-1:0] bank_valid,
  output logic             host_bank,
  output logic             cur_bank,
  output logic             rx_flag,
  output logic             busy,
  output logic             irq
);
  logic             free_ok;
  logic             recheck;
  logic             set_rx;
  logic [NBANK-1:0] valid_nx;

  assign busy    = bank_valid[cur_bank];
  assign free_ok = free_req && busy;
  assign set_rx  = (bank_done && host_bank == cur_bank) ||
                   (recheck && bank_valid[cur_bank]);

  always_comb begin
    valid_nx = bank_valid;
    if (bank_done) valid_nx[host_bank] = 1'b1;
    if (free_ok)   valid_nx[cur_bank]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_valid <= '0;
      host_bank  <= 1'b0;
      cur_bank   <= 1'b0;
      rx_flag    <= 1'b0;
      recheck    <= 1'b0;
      irq        <= 1'b0;
    end else begin
      bank_valid <= valid_nx;
      recheck    <= free_ok;
      irq        <= rx_flag && cfg_ie;
      if (bank_done) host_bank <= ~host_bank;
      if (free_ok)   cur_bank  <= ~cur_bank;
      if (set_rx)      rx_flag <= 1'b1;
      else if (clr_rx) rx_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_out_pingpong.sv
module usb_out_pingpong
  import ob_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_sop,
  input  logic              rx_byte_vld,
  input  logic [7:0]        rx_byte,
  input  logic              rx_eop,
  output logic              rx_nak,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              irq
);
  logic                         cfg_ie, cfg_multi;
  logic [CNT_W-1:0]             cfg_ep_size;
  logic [NBANK-1:0][ADDR_W-1:0] bank_base;
  logic [NBANK-1:0][CNT_W-1:0]  bank_msize;
  logic [NBANK-1:0][CNT_W-1:0]  bank_count;
  logic [NBANK-1:0]             sw_cnt_we;
  logic [CNT_W-1:0]             sw_cnt_data;
  logic                         clr_rx, free_req;
  logic                         rx_flag, busy, cur_bank, host_bank;
  logic [NBANK-1:0]             bank_valid;
  logic                         bank_done;

  ob_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk, .rst, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata,
    .cfg_ie, .cfg_multi, .cfg_ep_size, .bank_base, .bank_msize,
    .sw_cnt_we, .sw_cnt_data, .clr_rx, .free_req,
    .rx_flag, .busy, .cur_bank, .bank_valid, .bank_count
  );

  ob_rx_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rx (
    .clk, .rst, .rx_sop, .rx_byte_vld, .rx_byte, .rx_eop,
    .cfg_multi, .cfg_ep_size, .bank_base, .bank_msize,
    .sw_cnt_we, .sw_cnt_data, .host_bank,
    .host_full(bank_valid[host_bank]),
    .bank_count, .bank_done, .rx_nak, .ram_we, .ram_addr, .ram_wdata
  );

  ob_bank_ctrl u_bank (
    .clk, .rst, .bank_done, .clr_rx, .free_req, .cfg_ie,
    .bank_valid, .host_bank, .cur_bank, .rx_flag, .busy, .irq
  );
endmodule

// File: rtl/ob_checker.sv
module ob_checker (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       rx_flag,
  input logic       cfg_ie,
  input logic       ram_we,
  input logic [1:0] bank_valid,
  input logic       cur_bank,
  input logic       free_req,
  input logic       rx_sop,
  input logic       rx_nak
);
  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rx_flag && cfg_ie));

  assert_rx_needs_data_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_flag) |-> bank_valid[cur_bank]);

  assert_no_write_when_full_R10: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (bank_valid != 2'b11));

  assert_nak_after_sop_R10: assert property (@(posedge clk) disable iff (rst)
    rx_nak |-> $past(rx_sop));

  assert_cur_moves_on_free_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_bank) |-> $past(free_req && bank_valid[cur_bank]));
endmodule

bind usb_out_pingpong ob_checker u_chk (
  .clk(clk), .rst(rst), .irq(irq), .rx_flag(rx_flag), .cfg_ie(cfg_ie),
  .ram_we(ram_we), .bank_valid(bank_valid), .cur_bank(cur_bank),
  .free_req(free_req), .rx_sop(rx_sop), .rx_nak(rx_nak)
);

// File: tb/usb_out_pingpong_tb.sv
module usb_out_pingpong_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_sop = 0, rx_byte_vld = 0, rx_eop = 0;
  logic [7:0]  rx_byte = 0;
  logic        rx_nak, ram_we, irq;
  logic [9:0]  ram_addr;
  logic [7:0]  ram_wdata;
  logic        cpu_we = 0;
  logic [2:0]  cpu_addr = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;

  int vectors = 0, fails = 0, wr_count = 0;
  logic [7:0] mem [0:1023];
  logic [31:0] rd;
  logic nk;

  always #5 clk = ~clk;

  usb_out_pingpong u_dut (
    .clk, .rst, .rx_sop, .rx_byte_vld, .rx_byte, .rx_eop, .rx_nak,
    .ram_we, .ram_addr, .ram_wdata, .cpu_we, .cpu_addr, .cpu_wdata,
    .cpu_rdata, .irq
  );

  always @(posedge clk) if (ram_we) begin
    mem[ram_addr] <= ram_wdata;
    wr_count <= wr_count + 1;
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk); cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); @(negedge clk); cpu_we = 0;
  endtask

  task automatic cpu_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cpu_addr = a;
    @(posedge clk); @(negedge clk); d = cpu_rdata;
  endtask

  task automatic send_pkt(int len, logic [7:0] seed, output logic nak);
    @(negedge clk); rx_sop = 1;
    @(negedge clk); rx_sop = 0; nak = rx_nak;
    for (int i = 0; i < len; i++) begin
      rx_byte_vld = 1; rx_byte = seed + 8'(i);
      @(negedge clk);
    end
    rx_byte_vld = 0; rx_eop = 1;
    @(negedge clk); rx_eop = 0;
  endtask

  task automatic check_mem(string req, int base, int len, logic [7:0] seed);
    for (int i = 0; i < len; i++)
      check(req, mem[base + i], 8'(seed + 8'(i)));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    cpu_read(3'd1, rd); check("R1 stat", rd, 0);
    cpu_read(3'd0, rd); check("R1 cfg", rd, 0);
    check("R1 irq", irq, 0); check("R1 nak", rx_nak, 0);
    // R5 free ignored when not busy
    cpu_write(3'd1, 32'h2);
    cpu_read(3'd1, rd); check("R5 free ignored", rd, 0);
    // R11 configuration readback
    cpu_write(3'd0, 32'h0008_0001);
    cpu_read(3'd0, rd); check("R11 cfg", rd, 32'h0008_0001);
    cpu_write(3'd2, 32'h100); cpu_write(3'd4, 32'h280);
    cpu_read(3'd2, rd); check("R11 base0", rd, 32'h100);
    cpu_read(3'd4, rd); check("R11 base1", rd, 32'h280);

    // R2/R3/R4/R5/R7 single-packet sweep over lengths 1..8
    for (int k = 0; k < 8; k++) begin
      int b, len, base;
      logic [7:0] seed;
      b = k % 2; len = k + 1; base = b ? 32'h280 : 32'h100;
      seed = 8'(16 * k + 3);
      send_pkt(len, seed, nk);
      check("R10 no nak", nk, 0);
      cpu_read(3'd1, rd);
      check("R3 stat after rx", rd, 3 | (b << 2) | ((1 << b) << 3));
      check("R3 irq", irq, 1);
      cpu_read(3'(3 + 2 * b), rd); check("R2 count", rd[9:0], len);
      check_mem("R2 data", base, len, seed);
      cpu_write(3'd1, 32'h0);
      cpu_read(3'd1, rd); check("R4 zero write", rd[0], 1);
      cpu_write(3'd1, 32'h1);
      cpu_read(3'd1, rd); check("R4 clear", rd[0], 0);
      cpu_write(3'd1, 32'h2);
      cpu_read(3'd1, rd); check("R5 R7 free toggles", rd, (1 - b) << 2);
    end

    // R7 fill both banks, R10 NAK, R6 re-raise
    send_pkt(4, 8'h40, nk);
    send_pkt(5, 8'h50, nk);
    check_mem("R7 bank1 while bank0 held", 32'h280, 5, 8'h50);
    cpu_read(3'd1, rd); check("R7 both valid", rd, 32'h1B);
    begin
      int wc;
      wc = wr_count;
      send_pkt(3, 8'h90, nk);
      check("R10 nak", nk, 1);
      check("R10 no ram write", wr_count, wc);
    end
    cpu_read(3'd3, rd); check("R10 count0", rd[9:0], 4);
    cpu_read(3'd5, rd); check("R10 count1", rd[9:0], 5);
    check_mem("R10 bank0 intact", 32'h100, 4, 8'h40);
    cpu_write(3'd1, 32'h1);
    @(negedge clk); @(negedge clk);
    check("R6 irq low before free", irq, 0);
    cpu_write(3'd1, 32'h2);
    @(negedge clk); check("R6 irq one cycle", irq, 0);
    @(negedge clk); check("R6 irq two cycles", irq, 1);
    cpu_read(3'd1, rd); check("R6 stat", rd, 32'h17);
    cpu_write(3'd1, 32'h3);
    cpu_read(3'd1, rd); check("R5 both freed", rd, 0);

    // R3 enable off
    cpu_write(3'd0, 32'h0008_0000);
    send_pkt(2, 8'hA0, nk);
    @(negedge clk); @(negedge clk);
    check("R3 irq masked", irq, 0);
    cpu_read(3'd1, rd); check("R3 flag without enable", rd, 32'h0B);
    cpu_write(3'd1, 32'h3);

    // R8 multi-packet fill to size 24 in bank 1
    cpu_write(3'd0, 32'h0008_0003);
    cpu_write(3'd3, 32'h0018_0000);
    cpu_write(3'd5, 32'h0018_0000);
    send_pkt(8, 8'h60, nk);
    cpu_read(3'd1, rd); check("R8 not yet valid", rd, 32'h4);
    cpu_read(3'd5, rd); check("R8 partial count", rd[9:0], 8);
    send_pkt(8, 8'h68, nk);
    send_pkt(8, 8'h70, nk);
    cpu_read(3'd1, rd); check("R8 full valid", rd, 32'h17);
    cpu_read(3'd5, rd); check("R8 count", rd, 32'h0018_0018);
    check_mem("R8 packed data", 32'h280, 24, 8'h60);
    cpu_write(3'd1, 32'h3);

    // R9 short packet completes bank 0
    send_pkt(8, 8'h80, nk);
    cpu_read(3'd1, rd); check("R9 not valid after full packet", rd, 0);
    send_pkt(3, 8'h88, nk);
    cpu_read(3'd1, rd); check("R9 short completes", rd, 32'h0B);
    cpu_read(3'd3, rd); check("R9 count", rd[9:0], 11);
    check_mem("R9 data", 32'h100, 11, 8'h80);
    finish_run();
  end
endmodule